// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block carries one PCM sample per frame between a codec core and a time-division multiplexed serial bus. A frame-sync input marks each frame and a bit-clock input paces the bits. Transmit bits leave on rising bit-clock edges and receive bits are taken on falling edges. There are two bus ports, and each has its own data output, output enable and active-low slot enable. The codec side offers a parallel transmit byte and takes a parallel receive byte, which comes with a single-cycle valid strobe.

Two timing modes are offered. In the direct mode, the slot begins at the frame sync itself, and the slot-number inputs play no part. In the counted mode, the frame sync starts a bit counter. The slot is found by comparing the upper counter bits with a programmed slot number. Transmit and receive each have their own slot number and port select. A slot number beyond the last slot of the longest frame gives no activity. The mode input is captured at each frame start.

The bit clock and frame sync are sampled in the system clock domain. Each drops through a two-stage synchronizer, and its edges are detected there. Tri-state and open-drain behaviour is shown as a drive-enable and an active-low enable that the pads turn into real drivers.

Top module: `pcm_slot_port`

## Requirements
- R1: A frame begins at a bit-clock falling edge where the frame sync reads high and read low at the previous falling edge. Bit index 0 is sent at the next rising edge. A sync held high for many bits (square wave) starts no second frame.
- R2: With `delayedMode` low at frame start, the transmit and receive slots are bit indices 0 to 7, whatever `txSlot` and `rxSlot` hold.
- R3: With `delayedMode` high at frame start, slot n covers bit indices 8n to 8n+7, for n from 0 to 63.
- R4: In counted mode, a `txSlot` or `rxSlot` value of 64 or more gives no transmit drive and no receive strobe, respectively.
- R5: The transmit byte is taken at the first bit of the slot and sent MSB first, one bit per rising edge, on `txData[txPort]`.
- R6: During the transmit slot, only port `txPort` has `txDrive` at 1 and `slotEnN` at 0. At all other times every port has `txDrive` at 0, `txData` at 0 and `slotEnN` at 1.
- R7: Receive bits are shifted MSB first from `rxData[rxPort]` at falling edges in the receive slot only. The other port, and every bit outside the slot, are ignored.
- R8: `rxValid` is high for exactly one clock after the eighth receive bit, with the assembled byte on `rxByte`. `rxByte` changes only with `rxValid`.
- R9: Reset releases all outputs at once, even in the middle of a slot. Until the first frame start after reset there is no slot activity, and the port is in direct mode.
- R10: The bit counter stops after bit index 511. It does not wrap, and there is no activity until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bit clock and sync are sampled on it |
| rstN | input | 1 | Active-low asynchronous reset |
| bclkIn | input | 1 | Serial bit clock |
| fsyncIn | input | 1 | Frame sync (pulse or square wave) |
| delayedMode | input | 1 | 1 = counted slot mode, 0 = direct mode; captured at frame start |
| txSlot | input | 7 | Transmit slot number (counted mode) |
| rxSlot | input | 7 | Receive slot number (counted mode) |
| txPort | input | 1 | Port used for transmit |
| rxPort | input | 1 | Port used for receive |
| txByte | input | 8 | Sample to transmit |
| rxData | input | 2 | Serial receive data, one bit per port |
| txData | output | 2 | Serial transmit data, one bit per port |
| txDrive | output | 2 | Output enable for each port's data pad |
| slotEnN | output | 2 | Active-low slot enable per port (open-drain style) |
| rxByte | output | 8 | Last received sample |
| rxValid | output | 1 | One-clock strobe for a new `rxByte` |

## Verification
The bench uses the default parameters: two ports, 64 slots and 8-bit samples. This reaches the edges of the slot range: slot 63 at the very end of a 512-bit frame, and slot numbers 64 and 100 in the out-of-range case. The default port count lets the bench drive the port that is not selected with the inverse pattern, so R7 is checked against the wrong-port data. With a 512-bit frame in the run, the counter stop of R10 can be seen within a short simulation.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

  // Strobes from the slot control to the datapath, one clock wide.
  typedef struct packed {
    logic txLoad;     // first bit of the transmit slot: take byte, drive MSB
    logic txShift;    // later bit of the transmit slot: drive next bit
    logic txOff;      // rising edge outside the transmit slot: release pads
    logic rxCapture;  // falling edge inside the receive slot: take one bit
    logic rxLast;     // the captured bit is the last of the sample
  } slotStrobes_t;

endpackage

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_slot_pkg::*;
#(
  parameter int MAX_SLOTS = 64,
  parameter int SAMPLE_W  = 8,
  localparam int IDX_W  = $clog2(MAX_SLOTS),
  localparam int SLOT_W = IDX_W + 1,
  localparam int BIT_W  = $clog2(SAMPLE_W),
  localparam int CNT_W  = IDX_W + BIT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bclkIn,
  input  logic              fsyncIn,
  input  logic              delayedMode,
  input  logic [SLOT_W-1:0] txSlot,
  input  logic [SLOT_W-1:0] rxSlot,
  output slotStrobes_t      strb
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(MAX_SLOTS * SAMPLE_W - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = '1;

  logic [1:0]       bclkSync;
  logic [1:0]       fsSync;
  logic             bclkPrev;
  logic             fsSeen;
  logic             bRise;
  logic             bFall;
  logic             frameStart;
  logic [CNT_W-1:0] bitCnt;
  logic             running;
  logic             modeQ;
  logic             rxHit;
  logic             rxIdxLast;
  logic             txHit;

  // Sampling of the serial clocks into the system domain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkSync <= '0;
      fsSync   <= '0;
      bclkPrev <= 1'b0;
      fsSeen   <= 1'b0;
    end else begin
      bclkSync <= {bclkSync[0], bclkIn};
      fsSync   <= {fsSync[0], fsyncIn};
      bclkPrev <= bclkSync[1];
      if (bFall) fsSeen <= fsSync[1];
    end
  end

  assign bRise      = bclkSync[1] & ~bclkPrev;
  assign bFall      = ~bclkSync[1] & bclkPrev;
  assign frameStart = bFall & fsSync[1] & ~fsSeen;

  function automatic logic slotHit(input logic [CNT_W-1:0] c,
                                   input logic [SLOT_W-1:0] s,
                                   input logic dly);
    if (dly)
      return (s < SLOT_W'(MAX_SLOTS)) && (c[CNT_W-1:BIT_W] == s[IDX_W-1:0]);
    else
      return c[CNT_W-1:BIT_W] == '0;
  endfunction

  // Bit counter and receive window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      running   <= 1'b0;
      modeQ     <= 1'b0;
      rxHit     <= 1'b0;
      rxIdxLast <= 1'b0;
    end else begin
      if (bRise) begin
        rxHit     <= running & slotHit(bitCnt, rxSlot, modeQ);
        rxIdxLast <= bitCnt[BIT_W-1:0] == BIT_LAST;
        if (running) begin
          if (bitCnt == LAST_BIT) running <= 1'b0;
          bitCnt <= bitCnt + 1'b1;
        end
      end
      if (bFall) rxHit <= 1'b0;
      if (frameStart) begin
        bitCnt  <= '0;
        running <= 1'b1;
        modeQ   <= delayedMode;
      end
    end
  end

  assign txHit = running & slotHit(bitCnt, txSlot, modeQ);

  always_comb begin
    strb           = '0;
    strb.txLoad    = bRise & txHit & (bitCnt[BIT_W-1:0] == '0);
    strb.txShift   = bRise & txHit & (bitCnt[BIT_W-1:0] != '0);
    strb.txOff     = bRise & ~txHit;
    strb.rxCapture = bFall & rxHit;
    strb.rxLast    = rxIdxLast;
  end

  // R10: the counter halts at the end of the longest frame
  p_run_stops_r10: assert property (@(posedge clk) disable iff (!rstN)
    (bRise && running && bitCnt == LAST_BIT) |=> !running);

  // R7: each receive window admits one bit and then closes
  p_rx_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bFall && rxHit) |=> !rxHit);

endmodule

// File: rtl/pcm_slot_dp.sv
module pcm_slot_dp
  import pcm_slot_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int SAMPLE_W  = 8,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  slotStrobes_t         strb,
  input  logic [PORT_W-1:0]    txPort,
  input  logic [PORT_W-1:0]    rxPort,
  input  logic [SAMPLE_W-1:0]  txByte,
  input  logic [NUM_PORTS-1:0] rxData,
  output logic [NUM_PORTS-1:0] txData,
  output logic [NUM_PORTS-1:0] txDrive,
  output logic [NUM_PORTS-1:0] slotEnN,
  output logic [SAMPLE_W-1:0]  rxByte,
  output logic                 rxValid
);

  logic [SAMPLE_W-1:0] txSh;
  logic                txBit;
  logic                txOn;
  logic [PORT_W-1:0]   txPortQ;
  logic [SAMPLE_W-1:0] rxSh;
  logic                rxBitIn;

  assign rxBitIn = rxData[rxPort];

  // Transmit shifter and pad state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      txBit   <= 1'b0;
      txOn    <= 1'b0;
      txPortQ <= '0;
    end else if (strb.txLoad) begin
      txBit   <= txByte[SAMPLE_W-1];
      txSh    <= {txByte[SAMPLE_W-2:0], 1'b0};
      txOn    <= 1'b1;
      txPortQ <= txPort;
    end else if (strb.txShift) begin
      txBit <= txSh[SAMPLE_W-1];
      txSh  <= {txSh[SAMPLE_W-2:0], 1'b0};
    end else if (strb.txOff) begin
      txBit <= 1'b0;
      txOn  <= 1'b0;
    end
  end

  // Receive shifter and byte hand-off.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh    <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.rxCapture) begin
        rxSh <= {rxSh[SAMPLE_W-2:0], rxBitIn};
        if (strb.rxLast) begin
          rxByte  <= {rxSh[SAMPLE_W-2:0], rxBitIn};
          rxValid <= 1'b1;
        end
      end
    end
  end

  // Per-port pad view.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign txDrive[p] = txOn && (txPortQ == PORT_W'(p));
    assign txData[p]  = txDrive[p] & txBit;
    assign slotEnN[p] = ~txDrive[p];
  end

  // R6: never more than one port drives the bus
  p_onehot_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txDrive));

  // R8: the valid strobe lasts one clock
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R8: the received byte only moves together with the strobe
  p_byte_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxByte != $past(rxByte)) |-> rxValid);

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int MAX_SLOTS = 64,
  parameter int SAMPLE_W  = 8,
  localparam int SLOT_W = $clog2(MAX_SLOTS) + 1,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bclkIn,
  input  logic                 fsyncIn,
  input  logic                 delayedMode,
  input  logic [SLOT_W-1:0]    txSlot,
  input  logic [SLOT_W-1:0]    rxSlot,
  input  logic [PORT_W-1:0]    txPort,
  input  logic [PORT_W-1:0]    rxPort,
  input  logic [SAMPLE_W-1:0]  txByte,
  input  logic [NUM_PORTS-1:0] rxData,
  output logic [NUM_PORTS-1:0] txData,
  output logic [NUM_PORTS-1:0] txDrive,
  output logic [NUM_PORTS-1:0] slotEnN,
  output logic [SAMPLE_W-1:0]  rxByte,
  output logic                 rxValid
);

  slotStrobes_t strb;

  pcm_slot_ctrl #(
    .MAX_SLOTS (MAX_SLOTS),
    .SAMPLE_W  (SAMPLE_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .bclkIn      (bclkIn),
    .fsyncIn     (fsyncIn),
    .delayedMode (delayedMode),
    .txSlot      (txSlot),
    .rxSlot      (rxSlot),
    .strb        (strb)
  );

  pcm_slot_dp #(
    .NUM_PORTS (NUM_PORTS),
    .SAMPLE_W  (SAMPLE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txPort  (txPort),
    .rxPort  (rxPort),
    .txByte  (txByte),
    .rxData  (rxData),
    .txData  (txData),
    .txDrive (txDrive),
    .slotEnN (slotEnN),
    .rxByte  (rxByte),
    .rxValid (rxValid)
  );

endmodule

// File: tb/sim_pcm_slot_port.sv
`timescale 1ns/1ps
module sim_pcm_slot_port;

  typedef struct packed {
    logic [9:0] bits;
    logic [4:0] fsLen;
    logic       dly;
    logic [6:0] txS;
    logic [6:0] rxS;
    logic       txP;
    logic       rxP;
    logic [7:0] txB;
    logic [7:0] rxB;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{10'd32,  5'd1,  1'b0, 7'd3,   7'd2,   1'b0, 1'b0, 8'hA5, 8'h3C}, // R2
    '{10'd32,  5'd1,  1'b0, 7'd9,   7'd0,   1'b1, 1'b0, 8'h81, 8'hC3}, // R2
    '{10'd64,  5'd1,  1'b1, 7'd2,   7'd5,   1'b0, 1'b1, 8'h5A, 8'h96}, // R3
    '{10'd64,  5'd1,  1'b1, 7'd7,   7'd7,   1'b1, 1'b1, 8'hF0, 8'h0F}, // R3
    '{10'd512, 5'd1,  1'b1, 7'd63,  7'd0,   1'b0, 1'b0, 8'h01, 8'h80}, // R3
    '{10'd64,  5'd1,  1'b1, 7'd64,  7'd100, 1'b1, 1'b0, 8'hFF, 8'hAA}, // R4
    '{10'd16,  5'd1,  1'b1, 7'd1,   7'd1,   1'b1, 1'b0, 8'h6D, 8'hB2}, // R3
    '{10'd32,  5'd16, 1'b0, 7'd0,   7'd0,   1'b0, 1'b1, 8'h3C, 8'hE7}  // R1
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bclkIn = 1'b0;
  logic       fsyncIn = 1'b0;
  logic       delayedMode = 1'b0;
  logic [6:0] txSlot = '0;
  logic [6:0] rxSlot = '0;
  logic       txPort = 1'b0;
  logic       rxPort = 1'b0;
  logic [7:0] txByte = '0;
  logic [1:0] rxData = '0;
  logic [1:0] txData, txDrive, slotEnN;
  logic [7:0] rxByte;
  logic       rxValid;

  int nChecks = 0;
  int nFails  = 0;
  int gotCnt  = 0;
  logic [7:0] gotByte = '0;

  always #5 clk = ~clk;

  pcm_slot_port u0 (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .fsyncIn(fsyncIn),
    .delayedMode(delayedMode), .txSlot(txSlot), .rxSlot(rxSlot),
    .txPort(txPort), .rxPort(rxPort), .txByte(txByte), .rxData(rxData),
    .txData(txData), .txDrive(txDrive), .slotEnN(slotEnN),
    .rxByte(rxByte), .rxValid(rxValid)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      gotCnt++;
      gotByte = rxByte;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit hitExp(input int i, input logic [6:0] s, input logic dly);
    if (dly) return (s < 7'd64) && ((i / 8) == int'(s));
    return i < 8;
  endfunction

  // Drive n bit periods; quiet = no slot activity may appear.
  task automatic playBits(input int n, input int fsLen, input logic dly,
                          input bit quiet, input string tag);
    int rxHits = 0;
    for (int i = 0; i < n; i++) begin
      bit th = !quiet && hitExp(i, txSlot, dly);
      bit rh = !quiet && hitExp(i, rxSlot, dly);
      logic b;
      logic [1:0] eDrv, eDat;
      b = rh ? rxByte_exp(i) : logic'(i[0]);
      rxData  = (rh ? (rxPort ? {b, ~b} : {~b, b}) : {~b, b});
      fsyncIn = (i < fsLen - 1);
      bclkIn  = 1'b1;
      if (rh) rxHits++;
      repeat (8) @(posedge clk);
      #1;
      eDrv = th ? (2'b01 << txPort) : 2'b00;
      eDat = th ? ({1'b0, txByte[7 - (i % 8)]} << txPort) : 2'b00;
      check(tag, $sformatf("R5 R6 tx bit %0d", i),
            {10'd0, txDrive, txData, slotEnN}, {10'd0, eDrv, eDat, ~eDrv});
      bclkIn = 1'b0;
      repeat (8) @(posedge clk);
      #1;
    end
    check(tag, "R8 rx strobe count", 16'(gotCnt), 16'(rxHits / 8));
    if (rxHits == 8)
      check(tag, "R7 rx byte", {8'd0, gotByte}, {8'd0, expRx});
  endtask

  logic [7:0] expRx = '0;
  function automatic logic rxByte_exp(input int i);
    return expRx[7 - (i % 8)];
  endfunction

  task automatic frameStartPulse();
    fsyncIn = 1'b1;
    rxData  = 2'b00;
    bclkIn  = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    bclkIn = 1'b0;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic runVec(input vec_t v, input string tag);
    delayedMode = v.dly;
    txSlot = v.txS;  rxSlot = v.rxS;
    txPort = v.txP;  rxPort = v.rxP;
    txByte = v.txB;  expRx  = v.rxB;
    gotCnt = 0;
    frameStartPulse();
    playBits(int'(v.bits), int'(v.fsLen), v.dly, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: outputs released in reset
    check("R9", "reset outputs", {10'd0, txDrive, txData, slotEnN}, 16'h0003);
    check("R9", "reset rxValid", {15'd0, rxValid}, 16'd0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R9: no frame start yet, bit clock runs, nothing happens
    delayedMode = 1'b1; txSlot = 7'd0; rxSlot = 7'd0;
    gotCnt = 0;
    playBits(16, 0, 1'b1, 1'b1, "R9");

    for (int k = 0; k < NV; k++) begin
      string tag;
      if (VECS[k].fsLen > 5'd1)      tag = "R1";
      else if (!VECS[k].dly)         tag = "R2";
      else if (VECS[k].txS >= 7'd64) tag = "R4";
      else                           tag = "R3";
      runVec(VECS[k], tag);
    end

    // R10: after a full 512-bit frame, no wrap into slot 0
    runVec('{10'd512, 5'd1, 1'b1, 7'd1, 7'd2, 1'b1, 1'b1, 8'hC9, 8'h5E}, "R10");
    txSlot = 7'd0; rxSlot = 7'd0;
    gotCnt = 0;
    playBits(16, 0, 1'b1, 1'b1, "R10");

    // R9: reset in the middle of a transmit slot releases the pads
    delayedMode = 1'b0; txPort = 1'b1; txByte = 8'hFF;
    gotCnt = 0;
    frameStartPulse();
    fsyncIn = 1'b0;
    bclkIn = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    check("R9", "driving before reset", {14'd0, txDrive}, 16'h0002);
    rstN = 1'b0;
    #2;
    check("R9", "mid-slot reset outputs", {10'd0, txDrive, txData, slotEnN}, 16'h0003);
    repeat (2) @(posedge clk);
    #1;
    rstN = 1'b1;
    bclkIn = 1'b0;
    repeat (8) @(posedge clk);
    #1;
    playBits(8, 0, 1'b0, 1'b1, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule